// File: doc/BRIEF.md
# Multi-rate Tone Channel Timer Bank

This block holds the programmable down-counting timers that pace the tone channels of a sound generator. A single clock enable, asserted once per processor cycle, drives all of them. Each timer counts down, and when it reaches zero it reloads and emits a one-cycle step pulse. That pulse advances a downstream waveform sequencer, which is not part of this block.

There are three kinds of timer:
- One or more square-wave timers. Each has its own 11-bit period and runs on every processor cycle.
- A triangle timer. It has the same structure but is enabled only on every other processor cycle. A free-running parity bit, advanced by the clock enable, selects those cycles.
- A sample-playback timer. It takes its reload value from a fixed 16-entry non-linear rate table, indexed by a 4-bit selector.

All step pulses are combinational in the current clock enable and the counter state. A pulse is high in the cycle where the clock enable finds that counter at zero.

Top module: `tone_timer_bank`

## Requirements
- R1: While `rst_n` is low, every counter and the parity bit are cleared to zero. Because of this, the first `cpu_tick` after reset raises every step output in that same cycle.
- R2: Each square-wave timer behaves as follows on every `cpu_tick` cycle. If its counter is zero, the counter loads the timer's period and `pulse_step[i]` is high for that cycle. Otherwise the counter decrements by one. With a constant period P, steps occur on tick numbers k where k mod (P+1) = 0, counting ticks from 0 after reset.
- R3: In a cycle where `cpu_tick` is low, no step output is high and no counter changes.
- R4: The triangle timer is clocked only on ticks whose parity bit is 0. The parity bit starts at 0 and flips on each tick. With period P, `tri_step` is high on tick numbers k where k mod (2·(P+1)) = 0.
- R5: The sample-playback timer reloads with T−1, where T is the table entry chosen by `dmc_rate_sel`. The table for selectors 0 through 15 is 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54. `dmc_step` is high on tick numbers k where k mod T = 0, so the counter never exceeds 427.
- R6: A change to a period or to the rate selector is taken only at the timer's next reload. The count already in progress finishes unchanged.
- R7: The square-wave timers are independent. `pulse_period` bits [11·i+10 : 11·i] set the period of timer i, and that timer drives `pulse_step[i]`.
- R8: Cycles without `cpu_tick` do not advance the parity bit, so idle cycles never shift the triangle phase relative to the tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | Processor-cycle clock enable |
| pulse_period | input | NUM_PULSE*11 | Packed square-wave periods, timer i at bits [11i+10:11i] |
| tri_period | input | 11 | Triangle timer period |
| dmc_rate_sel | input | 4 | Rate table selector for the sample-playback timer |
| pulse_step | output | NUM_PULSE | Step pulse per square-wave timer |
| tri_step | output | 1 | Triangle timer step pulse |
| dmc_step | output | 1 | Sample-playback timer step pulse |

## Verification
The bench sweeps the shared period value through 0 to 15 and gives the two square-wave timers opposite periods, so that crossed wiring between timers shows up. The triangle period and the rate selector move with the same sweep, so all 16 table entries are covered, and each entry runs for two full step intervals; this catches any wrong table value or off-by-one reload. Idle cycles are inserted between ticks at a fixed cadence. They show whether a timer or the parity bit moves without a tick, which would shift every later step. Two further cases check the boundaries: a maximum period of 2047, and period or selector changes in the middle of a count. The latter tells deferred reload apart from immediate reload.

// File: rtl/ttd_pkg.sv
package ttd_pkg;
  localparam int PERIOD_W   = 11;
  localparam int RATE_SEL_W = 4;
  localparam int RATE_W     = 9;

  // Non-linear rate table for the sample-playback timer (R5)
  function automatic logic [RATE_W-1:0] rate_lookup(input logic [RATE_SEL_W-1:0] sel);
    case (sel)
      4'd0:  rate_lookup = 9'd428;
      4'd1:  rate_lookup = 9'd380;
      4'd2:  rate_lookup = 9'd340;
      4'd3:  rate_lookup = 9'd320;
      4'd4:  rate_lookup = 9'd286;
      4'd5:  rate_lookup = 9'd254;
      4'd6:  rate_lookup = 9'd226;
      4'd7:  rate_lookup = 9'd214;
      4'd8:  rate_lookup = 9'd190;
      4'd9:  rate_lookup = 9'd160;
      4'd10: rate_lookup = 9'd142;
      4'd11: rate_lookup = 9'd128;
      4'd12: rate_lookup = 9'd106;
      4'd13: rate_lookup = 9'd84;
      4'd14: rate_lookup = 9'd72;
      default: rate_lookup = 9'd54;
    endcase
  endfunction

  // Reload value is one less than the step interval
  function automatic logic [RATE_W-1:0] rate_reload(input logic [RATE_SEL_W-1:0] sel);
    rate_reload = rate_lookup(sel) - RATE_W'(1);
  endfunction
endpackage

// File: rtl/ttd_reload_counter.sv
module ttd_reload_counter #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic         step,
  output logic [W-1:0] count
);
  logic at_zero;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur, input logic [W-1:0] rl);
    next_count = (cur == '0) ? rl : cur - W'(1);
  endfunction

  assign at_zero = (count == '0);
  assign step    = en & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)  count <= '0;
    else if (en) count <= next_count(count, reload);
  end

  // R2 R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == $past(reload));
  // R2
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count != '0) |=> count == $past(count) - W'(1));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));
endmodule

// File: rtl/ttd_cycle_parity.sv
module ttd_cycle_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic even_slot
);
  logic par;

  assign even_slot = tick & ~par;

  always_ff @(posedge clk) begin
    if (!rst_n)    par <= 1'b0;
    else if (tick) par <= ~par;
  end

  // R4
  flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> par != $past(par));
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(par));
endmodule

// File: rtl/tone_timer_bank.sv
module tone_timer_bank
  import ttd_pkg::*;
#(
  parameter int NUM_PULSE = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_tick,
  input  logic [NUM_PULSE*PERIOD_W-1:0] pulse_period,
  input  logic [PERIOD_W-1:0]           tri_period,
  input  logic [RATE_SEL_W-1:0]         dmc_rate_sel,
  output logic [NUM_PULSE-1:0]          pulse_step,
  output logic                          tri_step,
  output logic                          dmc_step
);
  localparam logic [RATE_W-1:0] MAX_RELOAD = RATE_W'(427);

  logic                tri_en;
  logic [PERIOD_W-1:0] tri_count;
  logic [RATE_W-1:0]   dmc_count;
  logic [RATE_W-1:0]   dmc_reload;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PULSE; gi++) begin : g_pulse
      logic [PERIOD_W-1:0] cnt;
      ttd_reload_counter #(.W(PERIOD_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cpu_tick),
        .reload (pulse_period[gi*PERIOD_W +: PERIOD_W]),
        .step   (pulse_step[gi]),
        .count  (cnt)
      );
    end
  endgenerate

  ttd_cycle_parity u_par (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (cpu_tick),
    .even_slot (tri_en)
  );

  ttd_reload_counter #(.W(PERIOD_W)) u_tri (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (tri_en),
    .reload (tri_period),
    .step   (tri_step),
    .count  (tri_count)
  );

  assign dmc_reload = rate_reload(dmc_rate_sel);

  ttd_reload_counter #(.W(RATE_W)) u_dmc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cpu_tick),
    .reload (dmc_reload),
    .step   (dmc_step),
    .count  (dmc_count)
  );

  // R3
  tri_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tri_step |-> cpu_tick);
  // R4
  tri_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tri_en |=> !tri_en);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmc_count <= MAX_RELOAD);
endmodule

// File: tb/tb_tone_timer_bank.sv
module tb_tone_timer_bank;
  localparam int CLK_P = 10;
  localparam int NP    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_tick = 1'b0;
  logic [21:0]   pulse_period = '0;
  logic [10:0]   tri_period = '0;
  logic [3:0]    dmc_rate_sel = '0;
  logic [NP-1:0] pulse_step;
  logic          tri_step;
  logic          dmc_step;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  tone_timer_bank #(.NUM_PULSE(NP)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick),
    .pulse_period(pulse_period), .tri_period(tri_period),
    .dmc_rate_sel(dmc_rate_sel),
    .pulse_step(pulse_step), .tri_step(tri_step), .dmc_step(dmc_step)
  );

  function automatic int tbl(input int s);
    int t[16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                  190, 160, 142, 128, 106, 84, 72, 54};
    return t[s];
  endfunction

  task automatic chk(input string req, input string what, input int k, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s tick %0d: got %0b expected %0b", req, what, k, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // set cpu_tick at negedge, outputs settle, sample before next posedge
  task automatic drive(input logic t);
    @(negedge clk);
    cpu_tick = t;
    #1;
  endtask

  task automatic idle_check(input int k);
    drive(1'b0);
    chk("R3", "pulse0 idle", k, pulse_step[0], 1'b0);
    chk("R3", "pulse1 idle", k, pulse_step[1], 1'b0);
    chk("R3", "tri idle",    k, tri_step,      1'b0);
    chk("R3", "dmc idle",    k, dmc_step,      1'b0);
  endtask

  task automatic run_window(input int p0, input int p1, input int tp, input int sel,
                            input int nticks, input int gap);
    pulse_period = {11'(p1), 11'(p0)};
    tri_period   = 11'(tp);
    dmc_rate_sel = 4'(sel);
    do_reset();
    for (int k = 0; k < nticks; k++) begin
      if (gap > 0 && k % gap == 1) idle_check(k);
      drive(1'b1);
      chk("R2", "pulse0", k, pulse_step[0], (k % (p0 + 1)) == 0);
      chk("R7", "pulse1", k, pulse_step[1], (k % (p1 + 1)) == 0);
      chk("R4", "tri",    k, tri_step,      (k % (2 * (tp + 1))) == 0);
      chk("R5", "dmc",    k, dmc_step,      (k % tbl(sel)) == 0);
    end
    drive(1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: quiet before any tick, then every timer steps on the first tick
    pulse_period = {11'd7, 11'd5};
    tri_period   = 11'd3;
    dmc_rate_sel = 4'd4;
    do_reset();
    drive(1'b0);
    chk("R1", "pulse0 reset", 0, pulse_step[0], 1'b0);
    chk("R1", "tri reset",    0, tri_step,      1'b0);
    chk("R1", "dmc reset",    0, dmc_step,      1'b0);
    drive(1'b1);
    chk("R1", "pulse0 first", 0, pulse_step[0], 1'b1);
    chk("R1", "pulse1 first", 0, pulse_step[1], 1'b1);
    chk("R1", "tri first",    0, tri_step,      1'b1);
    chk("R1", "dmc first",    0, dmc_step,      1'b1);
    drive(1'b0);

    // R2 R4 R5 R7 R8: sweep periods and every rate selector, with idle gaps
    for (int p = 0; p < 16; p++)
      run_window(p, 15 - p, p, p, 2 * tbl(p) + 2, (p % 2 == 0) ? 3 : 0);

    // R2 R4: maximum period
    run_window(2047, 0, 2047, 15, 4100, 0);

    // R6: period / selector changes mid-count take effect at next reload
    pulse_period = {11'd0, 11'd10};
    tri_period   = 11'd0;
    dmc_rate_sel = 4'd15;
    do_reset();
    for (int k = 0; k < 200; k++) begin
      logic e0, ed;
      if (k == 3) begin
        pulse_period[10:0] = 11'd3;
        dmc_rate_sel = 4'd14;
      end
      drive(1'b1);
      e0 = (k == 0) || (k >= 11 && (k - 11) % 4 == 0);
      ed = (k == 0) || (k == 54) || (k == 126) || (k == 198);
      chk("R6", "pulse0 change", k, pulse_step[0], e0);
      chk("R6", "dmc change",    k, dmc_step,      ed);
    end
    drive(1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule